// File: doc/BRIEF.md
# Averaging Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation converter from one 11-bit control word. Writing the word with its launch bit set starts a conversion run. The block drives trial codes to an external DAC and reads back one comparator bit. It walks each conversion through a sampling step, ten bit decisions from the most significant bit down, and a load step. It can repeat this up to 32 times and report the truncated mean.

All sequencing runs in the system clock domain. A power-of-two divider gives a one-cycle advance enable, and the sequencer moves one step per enable. Three fields go straight to the analog side: the input channel, the reference choice and the serial-output enable. The launch bit doubles as the busy flag and clears itself when the run ends. At that point the result register updates and a one-cycle done pulse is raised.

Top module: `aux_conv_seq`

## Requirements
- R1: After synchronous reset the control word is zero. busy, done, result, dac_code, chan_sel, ref_sel, serial_en and sample_pulse are all 0.
- R2: A write with wr_data[0]=1 while idle sets busy in the next cycle. busy returns to 0 by itself when the run completes.
- R3: While busy is 1, writes are ignored entirely. This covers attempts to clear the launch bit and changes to the channel, reference, divider, averaging and serial fields.
- R4: Each conversion takes exactly 12 advance enables: one sample step, ten decisions and one load step. A run of n conversions with divide D keeps busy high for exactly 12*n*D system cycles after the write edge.
- R5: wr_data[9:7]=N divides the system clock by 2^N. Values 0 to 7 give divide by 1 to 128.
- R6: wr_data[6:4] selects the conversion count: 0→1, 1→2, 2→4, 3→8, 4→16, and 5, 6 or 7→32. The result is the sum of the conversions shifted right by log2 of the count, with truncation.
- R7: The search runs from MSB to LSB. Each trial sets the bit under test, and that bit is kept when cmp_in=1 (input at or above dac_code). A steady input v in 0..1023 converts to v. The first trial code is 512.
- R8: chan_sel equals control bits 3:2 (00 external 1, 01 external 2, 10 core supply/2, 11 I/O supply/2). ref_sel equals bit 1 (0 fixed reference, 1 supply). serial_en equals bit 10. A write with the launch bit 0 updates these fields without starting a run.
- R9: done is high for exactly one cycle, in the cycle where result takes its new value and busy has just fallen. result then holds until the next run completes.
- R10: sample_pulse is high for one system cycle before each sample step, exactly once per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 11 | Control word |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| dac_code | output | 10 | Current trial code to the DAC |
| sample_pulse | output | 1 | Sample step about to be taken |
| chan_sel | output | 2 | Input multiplexer select |
| ref_sel | output | 1 | Reference select |
| serial_en | output | 1 | Serial result output enable |
| result | output | 10 | Averaged conversion result |
| busy | output | 1 | Run in progress (self-clearing launch bit) |
| done | output | 1 | One-cycle pulse when result updates |

## Verification
A wrong step count or divider mask shows up at the ports within a single run, because busy stays high for the wrong number of cycles and the sample-pulse count differs from the conversion count. An error in the averager's count or shift, or in the keep/drop decision, appears in the first result of an affected configuration. Every run gets a varying input per conversion, so truncation errors are visible too. Leaking a write while busy changes a passthrough output on the very next cycle, or shortens the run.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    localparam int RES_W        = 10;
    localparam int AVG_LOG2_MAX = 5;
    localparam int DIV_LOG2_MAX = 7;
    localparam int SEL_W        = 3;
    localparam int CFG_W        = 11;
    localparam int ACC_W        = RES_W + AVG_LOG2_MAX;
    localparam int STEPS        = RES_W + 2;

    // control word, MSB first: bit 10 serial enable, 9:7 divider,
    // 6:4 averaging, 3:2 channel, 1 reference, 0 launch
    typedef struct packed {
        logic             serial_en;
        logic [SEL_W-1:0] div_sel;
        logic [SEL_W-1:0] avg_sel;
        logic [1:0]       chan;
        logic             ref_sel;
        logic             start;
    } aux_cfg_t;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_DECIDE,
        PH_LOAD
    } aux_phase_e;

    function automatic logic [SEL_W-1:0] avg_shift(input logic [SEL_W-1:0] sel);
        return (sel > SEL_W'(AVG_LOG2_MAX)) ? SEL_W'(AVG_LOG2_MAX) : sel;
    endfunction

    function automatic aux_phase_e phase_of(input logic [3:0] step);
        if (step == 4'd0)
            return PH_SAMPLE;
        else if (step == 4'(STEPS - 1))
            return PH_LOAD;
        else
            return PH_DECIDE;
    endfunction

endpackage

// File: rtl/aux_clk_div.sv
module aux_clk_div
    import aux_seq_pkg::*;
#(
    parameter int DIV_W = DIV_LOG2_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << div_sel);
    assign tick = run && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R5
    div_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != '0) |=> !tick);

endmodule

// File: rtl/aux_sar_core.sv
module aux_sar_core
    import aux_seq_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         cmp_in,
    output logic [W-1:0] dac_code,
    output logic         sample_pulse,
    output logic         conv_valid,
    output logic [W-1:0] conv_data
);

    localparam int LAST = W + 1;
    localparam int IDX_W = $clog2(W + 2);

    logic [3:0]     step_q;
    logic [W-1:0]   trial_q;
    logic [W-1:0]   trial_next;
    logic [W-1:0]   bit_mask;
    logic [IDX_W-1:0] bit_idx;
    aux_phase_e     phase;

    assign phase    = phase_of(step_q);
    assign bit_idx  = IDX_W'(W) - IDX_W'(step_q);
    assign bit_mask = W'(1) << bit_idx;

    always_comb begin
        trial_next = trial_q;
        if (!cmp_in)
            trial_next = trial_next & ~bit_mask;
        trial_next = trial_next | (bit_mask >> 1);
    end

    assign sample_pulse = run && tick && (phase == PH_SAMPLE);
    assign conv_valid   = run && tick && (phase == PH_LOAD);
    assign conv_data    = trial_q;
    assign dac_code     = trial_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            step_q  <= '0;
            trial_q <= '0;
        end else if (tick) begin
            unique case (phase)
                PH_SAMPLE: begin
                    trial_q <= W'(1) << (W - 1);
                    step_q  <= 4'd1;
                end
                PH_DECIDE: begin
                    trial_q <= trial_next;
                    step_q  <= step_q + 4'd1;
                end
                default: begin
                    step_q <= '0;
                end
            endcase
        end
    end

    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step_q <= 4'(LAST));

    // R7
    first_trial_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(sample_pulse)) |-> (dac_code == (W'(1) << (W - 1))));

endmodule

// File: rtl/aux_averager.sv
module aux_averager
    import aux_seq_pkg::*;
#(
    parameter int W      = RES_W,
    parameter int CNT_W  = AVG_LOG2_MAX,
    parameter int SUM_W  = W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] avg_sel,
    input  logic             conv_valid,
    input  logic [W-1:0]     conv_data,
    output logic             last,
    output logic [W-1:0]     result,
    output logic             done
);

    logic [SEL_W-1:0] shift;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;

    assign shift    = avg_shift(avg_sel);
    assign last_idx = ~({CNT_W{1'b1}} << shift);
    assign sum      = acc_q + SUM_W'(conv_data);
    assign last     = conv_valid && (cnt_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (conv_valid) begin
            acc_q <= last ? '0 : sum;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (last)
                result <= W'(sum >> shift);
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        conv_valid |-> (cnt_q <= last_idx));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/aux_conv_seq.sv
module aux_conv_seq
    import aux_seq_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             cmp_in,
    output logic [W-1:0]     dac_code,
    output logic             sample_pulse,
    output logic [1:0]       chan_sel,
    output logic             ref_sel,
    output logic             serial_en,
    output logic [W-1:0]     result,
    output logic             busy,
    output logic             done
);

    aux_cfg_t     cfg_q;
    logic         tick;
    logic         conv_valid;
    logic [W-1:0] conv_data;
    logic         last;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en && !cfg_q.start)
            cfg_q <= aux_cfg_t'(wr_data);
        else if (last)
            cfg_q.start <= 1'b0;
    end

    assign busy      = cfg_q.start;
    assign chan_sel  = cfg_q.chan;
    assign ref_sel   = cfg_q.ref_sel;
    assign serial_en = cfg_q.serial_en;

    aux_clk_div #(.DIV_W(DIV_LOG2_MAX)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .div_sel (cfg_q.div_sel),
        .tick    (tick)
    );

    aux_sar_core #(.W(W)) u_sar (
        .clk          (clk),
        .rst          (rst),
        .run          (busy),
        .tick         (tick),
        .cmp_in       (cmp_in),
        .dac_code     (dac_code),
        .sample_pulse (sample_pulse),
        .conv_valid   (conv_valid),
        .conv_data    (conv_data)
    );

    aux_averager #(.W(W), .CNT_W(AVG_LOG2_MAX)) u_avg (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .avg_sel    (cfg_q.avg_sel),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .last       (last),
        .result     (result),
        .done       (done)
    );

    // R3
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(chan_sel) && $stable(ref_sel) && $stable(serial_en)));

    // R9
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy));

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !busy) |-> done);

endmodule

// File: tb/test_aux_conv_seq.sv
module test_aux_conv_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [10:0] wr_data = '0;
    logic        cmp_in;
    logic [9:0]  dac_code;
    logic        sample_pulse;
    logic [1:0]  chan_sel;
    logic        ref_sel;
    logic        serial_en;
    logic [9:0]  result;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int conv_idx = 0;
    bit jit_on = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    aux_conv_seq i_aux_conv_seq (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .cmp_in       (cmp_in),
        .dac_code     (dac_code),
        .sample_pulse (sample_pulse),
        .chan_sel     (chan_sel),
        .ref_sel      (ref_sel),
        .serial_en    (serial_en),
        .result       (result),
        .busy         (busy),
        .done         (done)
    );

    function automatic int vin_of(input int ch, input int k, input bit j);
        int base;
        int v;
        case (ch)
            0: base = 1000;
            1: base = 0;
            2: base = 513;
            default: base = 1023;
        endcase
        v = base + (j ? (k * 37) % 23 : 0);
        return (v > 1023) ? 1023 : v;
    endfunction

    // analog model: comparator against the DAC trial level
    always_comb cmp_in = (vin_of(int'(chan_sel), conv_idx, jit_on) >= int'(dac_code));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int div, input int avg, input int ch, input bit rsel,
                       input bit ser, input bit jit, input int ignore_at);
        logic [10:0] w;
        int sh;
        int n;
        int d;
        int edges;
        int samples;
        int sum;
        int limit;
        int exp_res;
        sh = (avg > 5) ? 5 : avg;
        n = 1 << sh;
        d = 1 << div;
        w = {ser, 3'(div), 3'(avg), 2'(ch), rsel, 1'b1};
        limit = 12 * n * d + 50;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        conv_idx = 0;
        jit_on = jit;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        edges = 0;
        samples = 0;
        // R2
        check(busy == 1'b1, "R2 busy after launch", int'(busy), 1);
        while (!done && edges < limit) begin
            if (sample_pulse) begin
                samples++;
                conv_idx++;
            end
            if (edges == ignore_at) begin
                wr_en = 1'b1;
                wr_data = {~w[10:1], 1'b0};
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == ignore_at + 1) begin
                // R3
                check(chan_sel == 2'(ch) && busy, "R3 write during run ignored",
                      int'(chan_sel), ch);
            end
        end
        wr_en = 1'b0;
        sum = 0;
        for (int k = 1; k <= n; k++) sum += vin_of(ch, k, jit);
        exp_res = sum >> sh;
        // R4 R5
        check(edges == 12 * n * d, "R4 R5 run length", edges, 12 * n * d);
        // R10
        check(samples == n, "R10 sample pulses", samples, n);
        // R6 R7
        check(int'(result) == exp_res, "R6 R7 averaged result", int'(result), exp_res);
        // R2
        check(busy == 1'b0, "R2 launch bit self-clears", int'(busy), 0);
        // R8
        check({serial_en, ref_sel, chan_sel} == {ser, rsel, 2'(ch)}, "R8 passthrough fields",
              int'({serial_en, ref_sel, chan_sel}), int'({ser, rsel, 2'(ch)}));
        @(negedge clk);
        // R9
        check(done == 1'b0 && int'(result) == exp_res, "R9 single done pulse, result held",
              int'(done), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        check({busy, done, result, dac_code, chan_sel, ref_sel, serial_en, sample_pulse} == '0,
              "R1 reset state", int'(result), 0);

        // R8: idle write with launch bit clear only updates fields
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {1'b1, 3'd2, 3'd1, 2'd2, 1'b1, 1'b0};
        @(negedge clk);
        wr_en = 1'b0;
        check(chan_sel == 2'd2 && ref_sel && serial_en && !busy, "R8 idle field write",
              int'({serial_en, ref_sel, chan_sel, busy}), 'b11100);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R8 no run without launch bit", int'(busy), 0);

        // R7: first trial code is the MSB
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {1'b0, 3'd1, 3'd0, 2'd2, 1'b0, 1'b1};
        conv_idx = 0;
        jit_on = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check(dac_code == 10'd512, "R7 first trial code", int'(dac_code), 512);
        while (busy) @(negedge clk);
        check(result == 10'd513, "R7 steady input converts", int'(result), 513);

        // sweep divider and averaging settings
        for (int dv = 0; dv < 4; dv++) begin
            for (int av = 0; av < 8; av++) begin
                run(dv, av, (dv + av) % 4, av[0], dv[0], ((dv + av) % 4) != 3,
                    (dv == 1) ? 5 : -1);
            end
        end
        // boundaries: full-scale and zero inputs, slowest divider
        run(7, 0, 3, 1'b1, 1'b1, 1'b0, 40);
        run(0, 7, 1, 1'b0, 1'b0, 1'b0, -1);
        run(2, 6, 3, 1'b0, 1'b1, 1'b0, 7);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule